// File: doc/BRIEF.md
# Indexed register port with clock-measurement counter

This block is the register front end of a two-channel disk host adapter. The host reaches it through a 16-byte I/O window. Each channel owns an 8-byte half of that window. Inside its half, one byte selects an internal register and another byte reads or writes the selected register. Each channel keeps its own selector. The registers behind the two halves are:

- per-drive timing bytes for the master and slave drive of each channel;
- a read-only status byte that reports the fitted cable type;
- two PLL setup bytes, on the secondary channel only;
- a run-control byte, on the primary channel only.

The run-control byte starts and stops a 30-bit free-running down counter. The counter steps on a separate count-tick input that stands in for the PLL reference clock. Software lets it run for a known time and reads it back to estimate that clock. The counter is read as four byte-sized slices split over both channels. A reader that fetches the slices while the counter runs can therefore see a torn value.

The timing and PLL bytes also drive output ports toward the PLL and the drive-timing logic. Both of those sit outside this block.

Top module: `ata_idx_regport`

## Requirements
- R1: Bus address bit 3 selects the channel (0 primary, 1 secondary). Within a channel, offset 1 is the index byte and offset 3 is the data byte. Writes to any other offset are ignored, and reads of any other offset return 0x00.
- R2: Each channel has its own 8-bit index. A read at offset 1 returns it. It keeps its value until it is written again, and writing one channel's index leaves the other channel's index unchanged.
- R3: After reset, every writable register, both index bytes, the counter and `rdata_o` are zero, and the run bit is clear.
- R4: On each channel, indices 0x0C to 0x1B are read/write timing bytes. Indices 0x0C to 0x13 belong to the master drive and 0x14 to 0x1B to the slave drive. Index k appears on `timing_o[ch][k-0x0C]`.
- R5: A read-modify-write that clears bit 7 of timing byte 0x10 on a channel leaves the other seven bits of that byte unchanged.
- R6: Index 0x0B is read-only status. Bit 2 equals `cable40_i[ch]` (1 means a 40-wire cable, 0 means an 80-wire cable), the other bits read 0, and writes to it have no effect.
- R7: On the secondary channel, index 0x02 is the 7-bit feedback value: bit 7 reads 0 and bits 6:0 drive `pll_fb_o`. Index 0x03 is the 8-bit reference divider and drives `pll_ref_o`. On the primary channel, these two indices have no register behind them.
- R8: Index 0x01 on the primary channel is the read/write run-control byte, and its bit 6 enables the counter. Index 0x01 on the secondary channel has no register behind it.
- R9: While the run bit is set, the counter decrements by one on every clock with `cnt_tick_i` high and wraps from 0 to 0x3FFFFFFF. While the run bit is clear, the counter holds its value.
- R10: Counter slices are read at these indices:
  - primary 0x20: counter bits 7:0
  - primary 0x21: {0, counter bits 14:8}
  - secondary 0x20: counter bits 22:15
  - secondary 0x21: {0, counter bits 29:23}
- R11: Data reads of an index with no register behind it return 0x00, and data writes to such an index change nothing.
- R12: A read strobe is captured on the clock edge, so `rdata_o` shows the value one cycle after the strobe. `rdata_o` holds that value until the next read strobe, even when writes happen in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Byte address in the window; bit 3 selects the channel |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| cable40_i | input | 2 | Per-channel 40-wire cable indication |
| cnt_tick_i | input | 1 | Count enable standing in for the reference clock |
| pll_fb_o | output | 7 | PLL feedback value |
| pll_ref_o | output | 8 | PLL reference divider value |
| timing_o | output | 2x16x8 | Timing bytes per channel, per index |

## Verification
The counter is driven to the wrap boundary with a single tick from zero, so every slice must read all ones. A design that saturates or wraps at a width other than 30 bits shows up in the upper slices. The slices are read again after a few hundred further ticks, which catches slice boundaries that are off by one bit or taken from the wrong channel. Writing 0x40 to the secondary control index must leave the counter frozen, and clearing the primary run bit must stop it. These two checks separate a control byte that is shared between channels from one that is decoded per channel. Finally, the PLL feedback byte must mask its top bit, status writes must bounce off, and each channel's index must stay separate, because a design that shares the index or stores all eight bits of F returns the wrong byte on readback.

// File: rtl/ata_regport_pkg.sv
package ata_regport_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned CNT_W   = 30;
  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned TIM_N   = 16;
  localparam int unsigned TIM_AW  = $clog2(TIM_N);
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned OFF_W   = ADDR_W - 1;
  // each channel exposes an equal share of the counter: a full byte and a narrower byte
  localparam int unsigned CH_BITS = CNT_W / NUM_CH;
  localparam int unsigned LO_W    = DATA_W;
  localparam int unsigned HI_W    = CH_BITS - LO_W;
  localparam int unsigned PLL_F_W = 7;

  localparam logic [OFF_W-1:0] OFF_IDX  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_DATA = 3'd3;

  localparam logic [DATA_W-1:0] IDX_CTRL  = 8'h01;
  localparam logic [DATA_W-1:0] IDX_PLL_F = 8'h02;
  localparam logic [DATA_W-1:0] IDX_PLL_R = 8'h03;
  localparam logic [DATA_W-1:0] IDX_STAT  = 8'h0B;
  localparam logic [DATA_W-1:0] IDX_TIM   = 8'h0C;
  localparam logic [DATA_W-1:0] IDX_CNT_A = 8'h20;
  localparam logic [DATA_W-1:0] IDX_CNT_B = 8'h21;

  localparam int unsigned STAT_CABLE_BIT = 2;
  localparam int unsigned CTRL_RUN_BIT   = 6;
endpackage

// File: rtl/rp_timing_bank.sv
module rp_timing_bank #(
  parameter int unsigned N  = 16,
  parameter int unsigned W  = 8,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [W-1:0]        wdata_i,
  input  logic [AW-1:0]       raddr_i,
  output logic [W-1:0]        rdata_o,
  output logic [N-1:0][W-1:0] regs_o
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_o[i] <= '0;
      else if (we_i && waddr_i == AW'(i)) regs_o[i] <= wdata_i;
    end
  end

  assign rdata_o = regs_o[raddr_i];
endmodule

// File: rtl/rp_down_counter.sv
module rp_down_counter #(
  parameter int unsigned W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // modular subtraction gives the wrap to all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= '0;
    else if (run_i && tick_i) count_o <= count_o - ONE;
  end
endmodule

// File: rtl/rp_channel.sv
module rp_channel
  import ata_regport_pkg::*;
#(
  parameter int unsigned CH = 0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sel_i,
  input  logic [OFF_W-1:0]              off_i,
  input  logic                          wr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic                          cable40_i,
  input  logic [LO_W-1:0]               cnt_lo_i,
  input  logic [HI_W-1:0]               cnt_hi_i,
  output logic [DATA_W-1:0]             rd_byte_o,
  output logic [DATA_W-1:0]             idx_o,
  output logic                          run_o,
  output logic [PLL_F_W-1:0]            pll_fb_o,
  output logic [DATA_W-1:0]             pll_ref_o,
  output logic [TIM_N-1:0][DATA_W-1:0]  timing_o
);
  logic              idx_we, data_we;
  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-1:0] tim_diff;
  logic              tim_hit;
  logic [DATA_W-1:0] tim_rd;
  logic [DATA_W-1:0] ctrl_v;
  logic [DATA_W-1:0] data_val;

  assign idx_we  = sel_i && wr_i && (off_i == OFF_IDX);
  assign data_we = sel_i && wr_i && (off_i == OFF_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (idx_we) idx_q <= wdata_i;
  end
  assign idx_o = idx_q;

  // indices below the timing base wrap to large values and miss
  assign tim_diff = idx_q - IDX_TIM;
  assign tim_hit  = (tim_diff >> TIM_AW) == '0;

  rp_timing_bank #(.N(TIM_N), .W(DATA_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (data_we && tim_hit),
    .waddr_i (tim_diff[TIM_AW-1:0]),
    .wdata_i (wdata_i),
    .raddr_i (tim_diff[TIM_AW-1:0]),
    .rdata_o (tim_rd),
    .regs_o  (timing_o)
  );

  if (CH == 0) begin : g_pri
    logic [DATA_W-1:0] ctrl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q <= '0;
      else if (data_we && idx_q == IDX_CTRL) ctrl_q <= wdata_i;
    end
    assign ctrl_v    = ctrl_q;
    assign run_o     = ctrl_q[CTRL_RUN_BIT];
    assign pll_fb_o  = '0;
    assign pll_ref_o = '0;
  end else begin : g_sec
    logic [PLL_F_W-1:0] fb_q;
    logic [DATA_W-1:0]  ref_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fb_q  <= '0;
        ref_q <= '0;
      end else if (data_we) begin
        if (idx_q == IDX_PLL_F) fb_q  <= wdata_i[PLL_F_W-1:0];
        if (idx_q == IDX_PLL_R) ref_q <= wdata_i;
      end
    end
    assign ctrl_v    = '0;
    assign run_o     = 1'b0;
    assign pll_fb_o  = fb_q;
    assign pll_ref_o = ref_q;
  end

  always_comb begin
    data_val = '0;
    if (tim_hit) data_val = tim_rd;
    case (idx_q)
      IDX_CTRL:  data_val = ctrl_v;
      IDX_PLL_F: data_val = DATA_W'(pll_fb_o);
      IDX_PLL_R: data_val = pll_ref_o;
      IDX_STAT:  data_val[STAT_CABLE_BIT] = cable40_i;
      IDX_CNT_A: data_val = DATA_W'(cnt_lo_i);
      IDX_CNT_B: data_val = DATA_W'(cnt_hi_i);
      default:   ;
    endcase
  end

  always_comb begin
    case (off_i)
      OFF_IDX:  rd_byte_o = idx_q;
      OFF_DATA: rd_byte_o = data_val;
      default:  rd_byte_o = '0;
    endcase
  end
endmodule

// File: rtl/ata_idx_regport.sv
module ata_idx_regport
  import ata_regport_pkg::*;
(
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [ADDR_W-1:0]                        addr_i,
  input  logic                                     wr_i,
  input  logic                                     rd_i,
  input  logic [DATA_W-1:0]                        wdata_i,
  output logic [DATA_W-1:0]                        rdata_o,
  input  logic [NUM_CH-1:0]                        cable40_i,
  input  logic                                     cnt_tick_i,
  output logic [PLL_F_W-1:0]                       pll_fb_o,
  output logic [DATA_W-1:0]                        pll_ref_o,
  output logic [NUM_CH-1:0][TIM_N-1:0][DATA_W-1:0] timing_o
);
  logic [DATA_W-1:0]  rd_byte_w [NUM_CH];
  logic [DATA_W-1:0]  idx_w     [NUM_CH];
  logic [NUM_CH-1:0]  run_w;
  logic [PLL_F_W-1:0] fb_w      [NUM_CH];
  logic [DATA_W-1:0]  ref_w     [NUM_CH];
  logic [CNT_W-1:0]   cnt_val;
  logic               cnt_run;
  logic [DATA_W-1:0]  rdata_q;
  logic               ch_sel;

  assign ch_sel = addr_i[ADDR_W-1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rp_channel #(.CH(c)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (ch_sel == 1'(c)),
      .off_i     (addr_i[OFF_W-1:0]),
      .wr_i      (wr_i),
      .wdata_i   (wdata_i),
      .cable40_i (cable40_i[c]),
      .cnt_lo_i  (cnt_val[c*CH_BITS +: LO_W]),
      .cnt_hi_i  (cnt_val[c*CH_BITS+LO_W +: HI_W]),
      .rd_byte_o (rd_byte_w[c]),
      .idx_o     (idx_w[c]),
      .run_o     (run_w[c]),
      .pll_fb_o  (fb_w[c]),
      .pll_ref_o (ref_w[c]),
      .timing_o  (timing_o[c])
    );
  end

  // only the primary drives run, only the secondary drives the PLL bytes
  assign cnt_run   = |run_w;
  assign pll_fb_o  = fb_w[0] | fb_w[1];
  assign pll_ref_o = ref_w[0] | ref_w[1];

  rp_down_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (cnt_run),
    .tick_i  (cnt_tick_i),
    .count_o (cnt_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_byte_w[ch_sel];
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ata_idx_regport_chk.sv
module ata_idx_regport_chk (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [7:0]        rdata_o,
  input logic [1:0]        cable40_i,
  input logic              cnt_tick_i,
  input logic [1:0][15:0][7:0] timing_o,
  input logic              run,
  input logic [29:0]       count,
  input logic [7:0]        idx0,
  input logic [7:0]        idx1
);
  assert_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(count));

  assert_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt_tick_i) |=> (count == $past(count) - 30'd1));

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  assert_dead_offset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[2:0] != 3'd1 && addr_i[2:0] != 3'd3) |=> rdata_o == 8'h00);

  assert_status_pri_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 4'd3 && idx0 == 8'h0B) |=> rdata_o == {5'b0, $past(cable40_i[0]), 2'b0});

  assert_status_sec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 4'd11 && idx1 == 8'h0B) |=> rdata_o == {5'b0, $past(cable40_i[1]), 2'b0});

  assert_timing_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(timing_o));
endmodule

bind ata_idx_regport ata_idx_regport_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .rdata_o    (rdata_o),
  .cable40_i  (cable40_i),
  .cnt_tick_i (cnt_tick_i),
  .timing_o   (timing_o),
  .run        (cnt_run),
  .count      (cnt_val),
  .idx0       (idx_w[0]),
  .idx1       (idx_w[1])
);

// File: tb/tb_ata_idx_regport.sv
module tb_ata_idx_regport;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [3:0]  addr;
  logic        wr, rd;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [1:0]  cable40;
  logic        tick;
  logic [6:0]  pll_fb;
  logic [7:0]  pll_ref;
  logic [1:0][15:0][7:0] timing;

  ata_idx_regport dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .cable40_i(cable40), .cnt_tick_i(tick),
    .pll_fb_o(pll_fb), .pll_ref_o(pll_ref), .timing_o(timing)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen;
  logic [29:0] exp_cnt;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: a strobe sampled at a rising edge is answered by the next falling edge
  always @(posedge clk or negedge rst_n)
    if (!rst_n) rd_seen <= 1'b0; else rd_seen <= rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(32'hDEAD, 32'h0, "scoreboard underflow");
      else chk({24'h0, rdata}, {24'h0, exp_q.pop_front()}, tag_q.pop_front());
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [7:0] e, input string req);
    addr = a; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wreg(input int ch, input logic [7:0] idx, input logic [7:0] d);
    bus_wr(4'(ch*8+1), idx);
    bus_wr(4'(ch*8+3), d);
  endtask

  task automatic rreg(input int ch, input logic [7:0] idx, input logic [7:0] e, input string req);
    bus_wr(4'(ch*8+1), idx);
    bus_rd(4'(ch*8+3), e, req);
  endtask

  task automatic ticks(input int n, input bit running);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    if (running) exp_cnt = exp_cnt - 30'(n);
  endtask

  task automatic read_counter(input string req);
    rreg(0, 8'h20, exp_cnt[7:0], req);
    rreg(0, 8'h21, {1'b0, exp_cnt[14:8]}, req);
    rreg(1, 8'h20, exp_cnt[22:15], req);
    rreg(1, 8'h21, {1'b0, exp_cnt[29:23]}, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(32'h1, 32'h0, "watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr = 0; rd = 0; wdata = '0; cable40 = 2'b01; tick = 0;
    exp_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    chk({24'h0, rdata}, 32'h0, "R3 rdata");
    chk({31'h0, timing == '0}, 32'h1, "R3 timing");
    chk({25'h0, pll_fb}, 32'h0, "R3 pll_fb");
    chk({24'h0, pll_ref}, 32'h0, "R3 pll_ref");
    bus_rd(4'd1, 8'h00, "R3 index");
    rreg(0, 8'h01, 8'h00, "R3 run byte");
    read_counter("R3 counter");

    // R2 separate index bytes
    bus_wr(4'd1, 8'h0C);
    bus_wr(4'd9, 8'h13);
    bus_rd(4'd1, 8'h0C, "R2 primary index");
    bus_rd(4'd9, 8'h13, "R2 secondary index");

    // R4 timing bytes, master and slave
    wreg(0, 8'h0C, 8'hA5);
    chk({24'h0, timing[0][0]}, 32'hA5, "R4 timing out master");
    wreg(0, 8'h1B, 8'h3C);
    chk({24'h0, timing[0][15]}, 32'h3C, "R4 timing out slave");
    wreg(1, 8'h10, 8'hC7);
    chk({24'h0, timing[1][4]}, 32'hC7, "R4 timing out secondary");
    chk({24'h0, timing[0][4]}, 32'h00, "R4 other channel untouched");
    rreg(0, 8'h0C, 8'hA5, "R4 readback 0x0C");
    rreg(0, 8'h1B, 8'h3C, "R4 readback 0x1B");

    // R5 hold bit clear by read-modify-write
    rreg(1, 8'h10, 8'hC7, "R5 before");
    wreg(1, 8'h10, 8'hC7 & 8'h7F);
    rreg(1, 8'h10, 8'h47, "R5 after");

    // R6 status
    rreg(0, 8'h0B, 8'h04, "R6 primary 40-wire");
    rreg(1, 8'h0B, 8'h00, "R6 secondary 80-wire");
    wreg(0, 8'h0B, 8'hFF);
    rreg(0, 8'h0B, 8'h04, "R6 write ignored");
    cable40 = 2'b10;
    rreg(0, 8'h0B, 8'h00, "R6 primary 80-wire");
    rreg(1, 8'h0B, 8'h04, "R6 secondary 40-wire");

    // R7 PLL bytes
    wreg(1, 8'h02, 8'hFF);
    chk({25'h0, pll_fb}, 32'h7F, "R7 pll_fb");
    rreg(1, 8'h02, 8'h7F, "R7 F readback");
    wreg(1, 8'h03, 8'h0D);
    chk({24'h0, pll_ref}, 32'h0D, "R7 pll_ref");
    rreg(1, 8'h03, 8'h0D, "R7 R readback");
    wreg(0, 8'h02, 8'h55);
    rreg(0, 8'h02, 8'h00, "R7 primary has no F");
    chk({25'h0, pll_fb}, 32'h7F, "R7 F kept");

    // R11 and R1: empty index, dead offsets
    wreg(0, 8'h40, 8'h99);
    rreg(0, 8'h40, 8'h00, "R11 empty index");
    bus_wr(4'd0, 8'h77);
    bus_wr(4'd2, 8'h66);
    bus_rd(4'd1, 8'h40, "R1 dead offset write ignored");
    bus_rd(4'd2, 8'h00, "R1 dead offset read");
    bus_rd(4'd13, 8'h00, "R1 dead offset secondary");

    // R8 secondary run byte absent
    wreg(1, 8'h01, 8'h40);
    rreg(1, 8'h01, 8'h00, "R8 secondary 0x01 empty");
    ticks(5, 1'b0);
    read_counter("R8 counter still idle");

    // R9 wrap and decrement
    wreg(0, 8'h01, 8'h41);
    rreg(0, 8'h01, 8'h41, "R8 run byte readback");
    ticks(1, 1'b1);
    read_counter("R9 wrap");
    chk({2'b0, exp_cnt}, 32'h3FFFFFFF, "R9 model wrap");
    ticks(300, 1'b1);
    read_counter("R10 slices");
    wreg(0, 8'h01, 8'h00);
    ticks(50, 1'b0);
    read_counter("R9 frozen");

    // R12 hold across writes
    rreg(0, 8'h0C, 8'hA5, "R12 read");
    wreg(0, 8'h0D, 8'h11);
    repeat (3) @(negedge clk);
    chk({24'h0, rdata}, 32'hA5, "R12 rdata held");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    summary();
  end
endmodule